// File: doc/BRIEF.md
# Asynchronous SRAM Access Sequencer

This block lets a clocked host read and write an external asynchronous static RAM with a 1M-word by 4-bit array. The RAM has no clock. The block drives its 20-bit address, its active-low chip select, output enable and write enable, and a split data path made of output, output-enable and input. All of these leave the block from registers, so they change only on a rising clock edge. The number of clock cycles in each phase is a parameter. The defaults suit a 100 MHz system clock: one setup cycle, one write-pulse cycle, one hold cycle and a two-cycle read.

The host puts an address, a write flag and write data on its side and raises `req_i`. It keeps all of them steady until `ack_o` is seen. `ack_o` is high for a single cycle when the access completes, and in that cycle `rdata_o` carries the word that was read. When no access is in progress the RAM is held in standby and the block does not drive the data bus. A write that comes straight after a read first waits out turnaround cycles, so the RAM's output drivers are off before the block drives the bus.

Top module: `sram_ctrl`

## Requirements
- R1: For a read, `rdata_o` holds the value that was on `mem_dq_i` at the last clock edge of the read phase, and it is valid in the cycle where `ack_o` is high.
- R2: In reset and whenever no access is in progress, `mem_cs_no`, `mem_oe_no` and `mem_we_no` are 1 and `mem_dq_oe_o` is 0. Whenever `mem_cs_no` is 1, the other two strobes are 1 and the driver is off.
- R3: A write has WR_SETUP_CYC (default 1) cycles with chip select low, data driven and write enable high. It then has WR_PULSE_CYC (default 1) cycles with write enable low. It ends with WR_HOLD_CYC (default 1) cycles with write enable high, chip select low, and data and address unchanged.
- R4: `mem_addr_o` does not change in any cycle where `mem_cs_no` was 0 in both that cycle and the one before it.
- R5: `mem_dq_oe_o` is 0 whenever `mem_oe_no` is 0. Output enable is low only while chip select is low and write enable is high.
- R6: `ack_o` is high for exactly one cycle per access. A request still held during the cycle where `ack_o` is high does not start a new access at that cycle's closing edge.
- R7: A write that follows a read first spends TURN_CYC (default 1) cycles with all strobes high and the driver off. The driver never turns on in the cycle directly after one with output enable low.
- R8: A read holds chip select and output enable low for RD_CYC (default 2) consecutive cycles, with write enable high.
- R9: Count clock edges from the edge that accepts a request to the edge that raises `ack_o`, including both. A write takes 1+WR_SETUP_CYC+WR_PULSE_CYC+WR_HOLD_CYC edges (4), with TURN_CYC (1) more after a read. A read takes 1+RD_CYC edges (3).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request, held until acknowledge |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 20 | Word address |
| wdata_i | input | 4 | Write data |
| ack_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 4 | Read data, valid with `ack_o` |
| mem_addr_o | output | 20 | RAM address |
| mem_cs_no | output | 1 | RAM chip select, active low |
| mem_oe_no | output | 1 | RAM output enable, active low |
| mem_we_no | output | 1 | RAM write enable, active low |
| mem_dq_o | output | 4 | Data toward RAM |
| mem_dq_oe_o | output | 1 | Enable of the data pad driver |
| mem_dq_i | input | 4 | Data from RAM pads |

## Verification
The properties assume the host keeps `addr_i`, `we_i` and `wdata_i` steady from the raising of `req_i` until it sees `ack_o`. They also assume the host never lowers a request early. The bench does this by driving each request on a falling edge and releasing it only on a falling edge where the acknowledge is visible. In one case it deliberately holds the request one cycle longer. The RAM model drives `mem_dq_i` only while chip select and output enable are low and write enable is high. It stores a word on the rising edge of write enable, so the captured read value depends on the strobe ordering rather than on any settling time.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_TURN,
    ST_WSETUP,
    ST_WPULSE,
    ST_WHOLD,
    ST_READ
  } sram_st_e;

  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_ctrl_seq.sv
module sram_ctrl_seq
  import sram_ctrl_pkg::*;
#(
  parameter int WR_SETUP_CYC = 1,
  parameter int WR_PULSE_CYC = 1,
  parameter int WR_HOLD_CYC  = 1,
  parameter int RD_CYC       = 2,
  parameter int TURN_CYC     = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic we_i,
  output logic load_o,
  output logic cap_o,
  output logic ack_o,
  output logic cs_no,
  output logic oe_no,
  output logic we_no,
  output logic drv_o
);

  localparam int MAX_LEN = max_of(max_of(max_of(WR_SETUP_CYC, WR_PULSE_CYC),
                                         max_of(WR_HOLD_CYC, RD_CYC)), TURN_CYC);
  localparam int CNT_W   = $clog2(MAX_LEN + 1);

  sram_st_e         state_q, state_d;
  logic [CNT_W-1:0] cnt_q, phase_len;
  logic             last_rd_q, done, accept;

  always_comb begin
    unique case (state_q)
      ST_TURN:   phase_len = CNT_W'(TURN_CYC);
      ST_WSETUP: phase_len = CNT_W'(WR_SETUP_CYC);
      ST_WPULSE: phase_len = CNT_W'(WR_PULSE_CYC);
      ST_WHOLD:  phase_len = CNT_W'(WR_HOLD_CYC);
      ST_READ:   phase_len = CNT_W'(RD_CYC);
      default:   phase_len = CNT_W'(1);
    endcase
  end

  assign done   = (cnt_q == phase_len - CNT_W'(1));
  // no new access in the acknowledge cycle: host still holds the old request
  assign accept = (state_q == ST_IDLE) && req_i && !ack_o;
  assign load_o = accept;
  assign cap_o  = (state_q == ST_READ) && done;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (accept) begin
        if (we_i) state_d = (last_rd_q && (TURN_CYC > 0)) ? ST_TURN : ST_WSETUP;
        else      state_d = ST_READ;
      end
      ST_TURN:   if (done) state_d = ST_WSETUP;
      ST_WSETUP: if (done) state_d = ST_WPULSE;
      ST_WPULSE: if (done) state_d = ST_WHOLD;
      ST_WHOLD:  if (done) state_d = ST_IDLE;
      ST_READ:   if (done) state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      cnt_q     <= '0;
      last_rd_q <= 1'b0;
      ack_o     <= 1'b0;
      cs_no     <= 1'b1;
      oe_no     <= 1'b1;
      we_no     <= 1'b1;
      drv_o     <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= (state_d != state_q || state_q == ST_IDLE) ? '0 : cnt_q + CNT_W'(1);
      if (state_d == ST_READ)   last_rd_q <= 1'b1;
      if (state_d == ST_WSETUP) last_rd_q <= 1'b0;
      ack_o <= ((state_q == ST_WHOLD) || (state_q == ST_READ)) && done;
      // strobes follow the next state so every pin is a flop output
      cs_no <= (state_d == ST_IDLE) || (state_d == ST_TURN);
      oe_no <= (state_d != ST_READ);
      we_no <= (state_d != ST_WPULSE);
      drv_o <= (state_d == ST_WSETUP) || (state_d == ST_WPULSE) || (state_d == ST_WHOLD);
    end
  end

endmodule

// File: rtl/sram_ctrl_dp.sv
module sram_ctrl_dp #(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              cap_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] mem_dq_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic [DATA_W-1:0] rdata_o
);

  // address and write data only load on acceptance, so they stay fixed for the access
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_addr_o <= '0;
      mem_dq_o   <= '0;
    end else if (load_i) begin
      mem_addr_o <= addr_i;
      mem_dq_o   <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    rdata_o <= '0;
    else if (cap_i) rdata_o <= mem_dq_i;
  end

endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl #(
  parameter int ADDR_W       = 20,
  parameter int DATA_W       = 4,
  parameter int WR_SETUP_CYC = 1,
  parameter int WR_PULSE_CYC = 1,
  parameter int WR_HOLD_CYC  = 1,
  parameter int RD_CYC       = 2,
  parameter int TURN_CYC     = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              ack_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_cs_no,
  output logic              mem_oe_no,
  output logic              mem_we_no,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe_o,
  input  logic [DATA_W-1:0] mem_dq_i
);

  logic load, cap;

  sram_ctrl_seq #(
    .WR_SETUP_CYC(WR_SETUP_CYC),
    .WR_PULSE_CYC(WR_PULSE_CYC),
    .WR_HOLD_CYC (WR_HOLD_CYC),
    .RD_CYC      (RD_CYC),
    .TURN_CYC    (TURN_CYC)
  ) seq_i (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .req_i (req_i),
    .we_i  (we_i),
    .load_o(load),
    .cap_o (cap),
    .ack_o (ack_o),
    .cs_no (mem_cs_no),
    .oe_no (mem_oe_no),
    .we_no (mem_we_no),
    .drv_o (mem_dq_oe_o)
  );

  sram_ctrl_dp #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) dp_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load),
    .cap_i     (cap),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .mem_dq_i  (mem_dq_i),
    .mem_addr_o(mem_addr_o),
    .mem_dq_o  (mem_dq_o),
    .rdata_o   (rdata_o)
  );

endmodule

// File: rtl/sram_ctrl_chk.sv
module sram_ctrl_chk #(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ack_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              mem_cs_no,
  input logic              mem_oe_no,
  input logic              mem_we_no,
  input logic [DATA_W-1:0] mem_dq_o,
  input logic              mem_dq_oe_o
);

  p_standby_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_cs_no |-> (mem_oe_no && mem_we_no && !mem_dq_oe_o));

  p_pulse_driven_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_we_no |-> (mem_dq_oe_o && !mem_cs_no));

  p_write_setup_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(mem_we_no) |-> ($past(mem_dq_oe_o) && !$past(mem_cs_no)));

  p_write_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_we_no) |-> (mem_dq_oe_o && !mem_cs_no && $stable(mem_dq_o)));

  p_addr_stable_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mem_cs_no && !$past(mem_cs_no)) |-> $stable(mem_addr_o));

  p_no_contention_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_oe_no |-> (!mem_dq_oe_o && !mem_cs_no && mem_we_no));

  p_ack_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |=> !ack_o);

  p_ack_idle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> (mem_cs_no && !mem_dq_oe_o));

  p_turnaround_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_dq_oe_o) |-> $past(mem_oe_no));

endmodule

bind sram_ctrl sram_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .ack_o      (ack_o),
  .mem_addr_o (mem_addr_o),
  .mem_cs_no  (mem_cs_no),
  .mem_oe_no  (mem_oe_no),
  .mem_we_no  (mem_we_no),
  .mem_dq_o   (mem_dq_o),
  .mem_dq_oe_o(mem_dq_oe_o)
);

// File: tb/sram_ctrl_tb_top.sv
module sram_ctrl_tb_top;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0;
  logic        we_i = 1'b0;
  logic [19:0] addr_i = '0;
  logic [3:0]  wdata_i = '0;
  logic        ack_o;
  logic [3:0]  rdata_o;
  logic [19:0] mem_addr_o;
  logic        mem_cs_no, mem_oe_no, mem_we_no, mem_dq_oe_o;
  logic [3:0]  mem_dq_o, mem_dq_i;

  int n_cmp = 0;
  int n_bad = 0;

  always #2 clk_i = ~clk_i;

  sram_ctrl dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .ack_o(ack_o), .rdata_o(rdata_o),
    .mem_addr_o(mem_addr_o), .mem_cs_no(mem_cs_no), .mem_oe_no(mem_oe_no),
    .mem_we_no(mem_we_no), .mem_dq_o(mem_dq_o), .mem_dq_oe_o(mem_dq_oe_o),
    .mem_dq_i(mem_dq_i)
  );

  // RAM model: 16 words indexed by {addr[19], addr[2:0]}
  logic [3:0] ram_q [16];
  initial for (int i = 0; i < 16; i++) ram_q[i] = 4'h0;
  wire [3:0] ram_idx = {mem_addr_o[19], mem_addr_o[2:0]};
  assign mem_dq_i = (!mem_cs_no && !mem_oe_no && mem_we_no) ? ram_q[ram_idx] : 4'h0;
  always @(posedge mem_we_no)
    if (rst_ni && !mem_cs_no && mem_dq_oe_o) ram_q[ram_idx] = mem_dq_o;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  task automatic do_access(input bit w, input logic [19:0] a, input logic [3:0] d, input bit hold,
                           output logic [3:0] rd, output int edges, output int we_low,
                           output int oe_low, output int bad_addr, output int bad_drv,
                           output logic first_cs, output logic first_drv);
    edges = 0; we_low = 0; oe_low = 0; bad_addr = 0; bad_drv = 0; rd = 4'h0;
    first_cs = 1'b0; first_drv = 1'b0;
    @(negedge clk_i);
    req_i = 1'b1; we_i = w; addr_i = a; wdata_i = d;
    for (int k = 0; k < 64; k++) begin
      @(posedge clk_i);
      @(negedge clk_i);
      edges++;
      if (edges == 1) begin first_cs = mem_cs_no; first_drv = mem_dq_oe_o; end
      if (!mem_we_no) we_low++;
      if (!mem_oe_no) begin
        oe_low++;
        if (mem_dq_oe_o) bad_drv++;
      end
      if (!mem_cs_no && mem_addr_o != a) bad_addr++;
      if (ack_o) begin rd = rdata_o; break; end
    end
    if (hold) begin
      @(posedge clk_i);
      @(negedge clk_i);
      chk(mem_cs_no && !ack_o, "R6 held request not reaccepted", {mem_cs_no, ack_o}, 2'b10);
    end
    req_i = 1'b0;
  endtask

  // {write, address, data (write value or expected read value)}
  localparam int NVEC = 10;
  localparam logic [24:0] VEC [NVEC] = '{
    {1'b1, 20'h00001, 4'hA},
    {1'b1, 20'hFFFFF, 4'h5},
    {1'b1, 20'h80000, 4'h3},
    {1'b1, 20'h00002, 4'hC},
    {1'b0, 20'h00001, 4'hA},
    {1'b0, 20'hFFFFF, 4'h5},
    {1'b1, 20'h00001, 4'h6},
    {1'b0, 20'h00001, 4'h6},
    {1'b0, 20'h80000, 4'h3},
    {1'b0, 20'h00002, 4'hC}
  };

  initial begin
    repeat (150000) @(posedge clk_i);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired actual=0 expected=1");
    summary();
    $finish;
  end

  initial begin
    logic [3:0] rd;
    int edges, we_low, oe_low, bad_addr, bad_drv;
    logic first_cs, first_drv;
    bit prev_rd;
    prev_rd = 1'b0;

    repeat (3) @(negedge clk_i);
    chk(mem_cs_no && mem_oe_no && mem_we_no, "R2 strobes high in reset",
        {mem_cs_no, mem_oe_no, mem_we_no}, 3'b111);
    chk(!mem_dq_oe_o, "R2 driver off in reset", mem_dq_oe_o, 0);
    chk(!ack_o, "R6 no ack in reset", ack_o, 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    chk(mem_cs_no && mem_oe_no && mem_we_no && !mem_dq_oe_o, "R2 standby after reset",
        {mem_cs_no, mem_oe_no, mem_we_no, mem_dq_oe_o}, 4'b1110);

    for (int v = 0; v < NVEC; v++) begin
      bit          w;
      logic [19:0] a;
      logic [3:0]  d;
      {w, a, d} = VEC[v];
      do_access(w, a, d, 1'b0, rd, edges, we_low, oe_low, bad_addr, bad_drv, first_cs, first_drv);
      chk(bad_addr == 0, "R4 address stable under chip select", bad_addr, 0);
      chk(bad_drv == 0, "R5 no drive with output enable low", bad_drv, 0);
      if (w) begin
        chk(edges == (prev_rd ? 5 : 4), "R9 write latency (R7 adds turnaround)", edges, prev_rd ? 5 : 4);
        chk(we_low == 1, "R3 write pulse cycles", we_low, 1);
        chk(first_cs == prev_rd, "R7 turnaround keeps chip select high", first_cs, prev_rd);
        chk(first_drv == !prev_rd, "R3 data driven in setup cycle", first_drv, !prev_rd);
      end else begin
        chk(edges == 3, "R9 read latency", edges, 3);
        chk(oe_low == 2, "R8 output enable low cycles", oe_low, 2);
        chk(rd == d, "R1 read data", rd, d);
      end
      prev_rd = !w;
    end

    // request held across the acknowledge cycle
    do_access(1'b0, 20'h00005, 4'h0, 1'b1, rd, edges, we_low, oe_low, bad_addr, bad_drv, first_cs, first_drv);
    chk(rd == 4'h0, "R1 unwritten word reads zero", rd, 0);
    repeat (3) @(negedge clk_i);
    chk(mem_cs_no && mem_oe_no && mem_we_no && !mem_dq_oe_o, "R2 standby between accesses",
        {mem_cs_no, mem_oe_no, mem_we_no, mem_dq_oe_o}, 4'b1110);

    // write directly after a read, then confirm both words
    do_access(1'b1, 20'h00005, 4'h9, 1'b0, rd, edges, we_low, oe_low, bad_addr, bad_drv, first_cs, first_drv);
    chk(edges == 5, "R7 turnaround after held read", edges, 5);
    do_access(1'b0, 20'h00005, 4'h0, 1'b0, rd, edges, we_low, oe_low, bad_addr, bad_drv, first_cs, first_drv);
    chk(rd == 4'h9, "R1 read after turnaround write", rd, 4'h9);
    do_access(1'b0, 20'hFFFFF, 4'h0, 1'b0, rd, edges, we_low, oe_low, bad_addr, bad_drv, first_cs, first_drv);
    chk(rd == 4'h5, "R1 neighbour word untouched", rd, 4'h5);

    // ack lasts one cycle
    @(negedge clk_i);
    chk(!ack_o, "R6 ack single cycle", ack_o, 0);

    summary();
    $finish;
  end

endmodule